// File: doc/BRIEF.md
# Ring Bus Member Arbitration Controller

This block is the per-node controller for an ordinary member of a ring bus with a shared clock and a daisy-chained data loop. The bus clock and the data arriving from the upstream neighbour are sampled with a faster local clock. Their edges are turned into single-cycle pulses, and those pulses step a small state machine. While the bus is idle, the node passes its data input straight through to its data output and forwards the bus clock. A local transmit request pulls the data line low to ask for the bus. Because a requester breaks the chain, the winner depends on where it sits in the ring.

A normal arbitration round ends at a rising bus clock edge. One extra priority cycle follows it, and in that cycle a node further along the loop can take the bus away from the first winner. The node that finally wins switches its output from forwarded data to local transmit data at the next falling bus edge. It pulses a consume strobe on every falling edge after that. A node that loses, or never asked, listens to the leading address bits and moves to a receiving or an ignoring state. Both of those states keep forwarding. A session ends when the neighbouring interjection logic applies the synchronous reset.

Top module: `ring_arb_node`

## Requirements
- R1: After reset, and in idle with no local request, `bus_dout` equals `bus_din`. `won`, `lost` and `addressed` are 0.
- R2: In idle with `tx_req`=1, `bus_dout` is 0. During normal arbitration (bus clock low after a falling edge in idle), a node that held `tx_req` at that falling edge drives 0, and any other node forwards `bus_din`.
- R3: At the rising bus edge that ends normal arbitration, a requesting node that samples `bus_din`=1 becomes the first winner. A requesting node that samples 0 does not.
- R4: In the priority cycle (from the next falling bus edge to the rising edge that follows it), a node whose `prio_req` was 1 at that falling edge drives 0. A first winner without a priority request drives 1 and does not forward. Every other node forwards `bus_din`.
- R5: At the rising edge that latches the priority result, a priority requester wins if `bus_din`=1. A first winner without a priority request keeps the bus only if `bus_din`=0. `won` and `lost` are never both 1, and once set, `won` holds until reset.
- R6: A node that requested in either round and did not win raises `lost`. A node that did not request keeps `lost`=0. Both kinds forward `bus_din`.
- R7: At the first falling bus edge after winning, and at every later falling edge, `bus_dout` equals `tx_data` and `tx_pop` pulses for exactly one local cycle.
- R8: A node that did not win shifts `bus_din` in at each rising bus edge after the latch edge, MSB first. After `ADDR_W` bits, if the value equals `node_addr`, it asserts `addressed`.
- R9: If those `ADDR_W` bits differ from `node_addr`, `addressed` stays 0 and `bus_dout` keeps following `bus_din`.
- R10: `bus_clk_out` always equals `bus_clk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_in | input | 1 | Bus clock from the upstream side |
| bus_din | input | 1 | Data from the upstream neighbour |
| tx_req | input | 1 | Local request to transmit |
| prio_req | input | 1 | Local request for the priority cycle |
| node_addr | input | ADDR_W | Address of this node |
| tx_data | input | 1 | Current transmit bit |
| bus_dout | output | 1 | Data to the downstream neighbour |
| bus_clk_out | output | 1 | Forwarded bus clock |
| won | output | 1 | Node owns the bus |
| lost | output | 1 | Node requested but did not win |
| addressed | output | 1 | Leading address bits matched `node_addr` |
| tx_pop | output | 1 | One-cycle strobe: a transmit bit was consumed |

## Verification
On every local cycle, the bound checker enforces that `won` and `lost` are mutually exclusive and that `won` holds once set. It also checks that `addressed` never coexists with `won` and rises only out of the address-compare state, that the consume strobe lasts a single cycle, and that idle forwarding matches the input. The bench's scenarios are needed for the outcome of each arbitration round: a plain win, a preemption of the first winner, a win and a loss in the priority cycle, and a non-participant. Only those scenarios show the non-forwarding drive during the priority cycle, the switch to transmit data, and the match and mismatch paths of the address compare.

// File: rtl/ring_arb_pkg.sv
`timescale 1ns/1ps
package ring_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_PRIO,
        ST_WAITTX,
        ST_TX,
        ST_ADDR,
        ST_RECV,
        ST_IGNORE
    } node_st_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } bus_edge_t;

    // Result at the latch edge of the priority cycle.
    function automatic logic prio_outcome(input logic own_prio,
                                          input logic first_win,
                                          input logic din_lvl);
        return own_prio ? din_lvl : (first_win & ~din_lvl);
    endfunction

    // Drive value while the priority cycle is armed (also until begin-transmission).
    function automatic logic prio_drive(input logic own_prio,
                                        input logic first_win,
                                        input logic din_raw);
        return own_prio ? 1'b0 : (first_win ? 1'b1 : din_raw);
    endfunction

endpackage

// File: rtl/ring_sync_edge.sv
`timescale 1ns/1ps
module ring_sync_edge
    import ring_arb_pkg::*;
#(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        raw,
    output bus_edge_t [W-1:0]   edges
);
    localparam int PIPE_W = STAGES + 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [PIPE_W-1:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[PIPE_W-2:0], raw[i]};
            end
        end

        always_comb begin
            edges[i].level = pipe[STAGES-1];
            edges[i].rise  = pipe[STAGES-1] & ~pipe[STAGES];
            edges[i].fall  = ~pipe[STAGES-1] & pipe[STAGES];
        end
    end
endmodule

// File: rtl/ring_addr_match.sv
`timescale 1ns/1ps
module ring_addr_match #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              hit
);
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_W);

    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en && !done) begin
            shreg <= {shreg[ADDR_W-2:0], bit_in};
            cnt   <= cnt + 1'b1;
        end
    end

    assign done = (cnt == FULL);
    assign hit  = done && (shreg == addr);
endmodule

// File: rtl/ring_arb_fsm.sv
`timescale 1ns/1ps
module ring_arb_fsm
    import ring_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_rise,
    input  logic     clk_fall,
    input  logic     din_lvl,
    input  logic     tx_req,
    input  logic     prio_req,
    input  logic     addr_done,
    input  logic     addr_hit,
    output node_st_e state,
    output logic     req_q,
    output logic     first_win_q,
    output logic     prio_q,
    output logic     armed_q,
    output logic     lost_q,
    output logic     tx_pop,
    output logic     addr_clear,
    output logic     addr_shift
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_q       <= 1'b0;
            first_win_q <= 1'b0;
            prio_q      <= 1'b0;
            armed_q     <= 1'b0;
            lost_q      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (clk_fall) begin
                        req_q <= tx_req;
                        state <= ST_ARB;
                    end
                end
                ST_ARB: begin
                    if (clk_rise) begin
                        first_win_q <= req_q & din_lvl;
                        prio_q      <= 1'b0;
                        armed_q     <= 1'b0;
                        state       <= ST_PRIO;
                    end
                end
                ST_PRIO: begin
                    if (!armed_q && clk_fall) begin
                        armed_q <= 1'b1;
                        prio_q  <= prio_req;
                    end else if (armed_q && clk_rise) begin
                        if (prio_outcome(prio_q, first_win_q, din_lvl)) begin
                            state <= ST_WAITTX;
                        end else begin
                            lost_q <= req_q | prio_q;
                            state  <= ST_ADDR;
                        end
                    end
                end
                ST_WAITTX: begin
                    if (clk_fall) begin
                        state <= ST_TX;
                    end
                end
                ST_ADDR: begin
                    if (addr_done) begin
                        state <= addr_hit ? ST_RECV : ST_IGNORE;
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end

    assign tx_pop     = ((state == ST_WAITTX) || (state == ST_TX)) && clk_fall;
    assign addr_clear = (state != ST_ADDR);
    assign addr_shift = (state == ST_ADDR) && clk_rise;
endmodule

// File: rtl/ring_arb_node.sv
`timescale 1ns/1ps
module ring_arb_node
    import ring_arb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk_in,
    input  logic              bus_din,
    input  logic              tx_req,
    input  logic              prio_req,
    input  logic [ADDR_W-1:0] node_addr,
    input  logic              tx_data,
    output logic              bus_dout,
    output logic              bus_clk_out,
    output logic              won,
    output logic              lost,
    output logic              addressed,
    output logic              tx_pop
);
    localparam int N_SYNC = 2;
    localparam int IDX_CLK = 0;
    localparam int IDX_DIN = 1;

    bus_edge_t [N_SYNC-1:0] edges;
    node_st_e node_st;
    logic req_q, first_win_q, prio_q, armed_q, lost_q;
    logic addr_clear, addr_shift, addr_done, addr_hit;
    logic unused_edge_bits;

    ring_sync_edge #(.W(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .raw   ({bus_din, bus_clk_in}),
        .edges (edges)
    );

    assign unused_edge_bits = ^{edges[IDX_CLK].level, edges[IDX_DIN].rise, edges[IDX_DIN].fall};

    ring_arb_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .clk_rise    (edges[IDX_CLK].rise),
        .clk_fall    (edges[IDX_CLK].fall),
        .din_lvl     (edges[IDX_DIN].level),
        .tx_req      (tx_req),
        .prio_req    (prio_req),
        .addr_done   (addr_done),
        .addr_hit    (addr_hit),
        .state       (node_st),
        .req_q       (req_q),
        .first_win_q (first_win_q),
        .prio_q      (prio_q),
        .armed_q     (armed_q),
        .lost_q      (lost_q),
        .tx_pop      (tx_pop),
        .addr_clear  (addr_clear),
        .addr_shift  (addr_shift)
    );

    ring_addr_match #(.ADDR_W(ADDR_W)) match_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (addr_clear),
        .shift_en (addr_shift),
        .bit_in   (edges[IDX_DIN].level),
        .addr     (node_addr),
        .done     (addr_done),
        .hit      (addr_hit)
    );

    // Output data mux: shoot-through forwarding, request drive, or transmit data.
    always_comb begin
        case (node_st)
            ST_IDLE:   bus_dout = tx_req ? 1'b0 : bus_din;
            ST_ARB:    bus_dout = req_q ? 1'b0 : bus_din;
            ST_PRIO:   bus_dout = armed_q ? prio_drive(prio_q, first_win_q, bus_din)
                                          : (req_q ? 1'b0 : bus_din);
            ST_WAITTX: bus_dout = prio_drive(prio_q, first_win_q, bus_din);
            ST_TX:     bus_dout = tx_data;
            default:   bus_dout = bus_din;
        endcase
    end

    assign bus_clk_out = bus_clk_in;
    assign won         = (node_st == ST_WAITTX) || (node_st == ST_TX);
    assign lost        = lost_q;
    assign addressed   = (node_st == ST_RECV);
endmodule

// File: rtl/ring_arb_node_chk.sv
`timescale 1ns/1ps
module ring_arb_node_chk
    import ring_arb_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input node_st_e state,
    input logic     tx_req,
    input logic     bus_din,
    input logic     bus_dout,
    input logic     won,
    input logic     lost,
    input logic     addressed,
    input logic     tx_pop
);
    // R1
    idle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !tx_req) |-> (bus_dout == bus_din));

    // R5
    win_lose_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(won && lost));

    // R5
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        won |=> won);

    // R7
    pop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop |=> !tx_pop);

    // R8
    addr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        addressed |-> !won);

    // R8
    addr_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addressed) |-> ($past(state) == ST_ADDR));
endmodule

bind ring_arb_node ring_arb_node_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .state     (node_st),
    .tx_req    (tx_req),
    .bus_din   (bus_din),
    .bus_dout  (bus_dout),
    .won       (won),
    .lost      (lost),
    .addressed (addressed),
    .tx_pop    (tx_pop)
);

// File: tb/ring_arb_node_tb_top.sv
`timescale 1ns/1ps
module ring_arb_node_tb_top;
    localparam int AW   = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_clk_in = 1'b1;
    logic bus_din = 1'b1;
    logic tx_req = 1'b0;
    logic prio_req = 1'b0;
    logic [AW-1:0] node_addr = 8'hA5;
    logic tx_data = 1'b0;
    logic bus_dout, bus_clk_out, won, lost, addressed, tx_pop;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ring_arb_node #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_clk_in(bus_clk_in), .bus_din(bus_din),
        .tx_req(tx_req), .prio_req(prio_req), .node_addr(node_addr), .tx_data(tx_data),
        .bus_dout(bus_dout), .bus_clk_out(bus_clk_out), .won(won), .lost(lost),
        .addressed(addressed), .tx_pop(tx_pop)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_clk_in = 1'b1; bus_din = 1'b1;
        tx_req = 1'b0; prio_req = 1'b0; tx_data = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_half();
    endtask

    // Run a normal and a priority round; checks drive during both.
    task automatic run_arb(input logic req, input logic arb_din, input logic prio,
                           input logic latch_din, input logic exp_prio_dout);
        tx_req = req;
        bus_clk_in = 1'b0;
        wait_half();
        bus_din = 1'b0;
        #1;
        check("R2 arb drive", bus_dout, req ? 1'b0 : 1'b0);
        bus_din = 1'b1;
        #1;
        check("R2 arb drive/forward", bus_dout, req ? 1'b0 : 1'b1);
        bus_din = arb_din;
        bus_clk_in = 1'b1;
        wait_half();
        tx_req = 1'b0;
        prio_req = prio;
        bus_clk_in = 1'b0;
        wait_half();
        prio_req = 1'b0;
        bus_din = latch_din;
        #1;
        check("R4 priority cycle drive", bus_dout, exp_prio_dout);
        bus_clk_in = 1'b1;
        wait_half();
    endtask

    task automatic t_reset_idle();
        do_reset();
        check("R1 won after reset", won, 1'b0);
        check("R1 lost after reset", lost, 1'b0);
        check("R1 addressed after reset", addressed, 1'b0);
        bus_din = 1'b0; #1;
        check("R1 idle forward 0", bus_dout, 1'b0);
        bus_din = 1'b1; #1;
        check("R1 idle forward 1", bus_dout, 1'b1);
        bus_clk_in = 1'b0; #1;
        check("R10 clock forward 0", bus_clk_out, 1'b0);
        bus_clk_in = 1'b1; #1;
        check("R10 clock forward 1", bus_clk_out, 1'b1);
        tx_req = 1'b1; #1;
        check("R2 idle request drives low", bus_dout, 1'b0);
        tx_req = 1'b0; #1;
    endtask

    task automatic t_plain_win();
        int pops = 0;
        do_reset();
        // first winner, no priority, din low at latch: drives 1 (R4), keeps bus (R3, R5)
        run_arb(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R3 R5 plain win", won, 1'b1);
        check("R5 plain win lost", lost, 1'b0);
        bus_clk_in = 1'b0;
        for (int i = 0; i < HALF + 2; i++) begin
            @(negedge clk);
            if (tx_pop) pops++;
        end
        checks++;
        if (pops != 1) begin
            fails++;
            $display("FAIL R7 tx_pop pulses: actual %0d expected 1", pops);
        end
        tx_data = 1'b1; bus_din = 1'b0; #1;
        check("R7 dout follows tx_data 1", bus_dout, 1'b1);
        tx_data = 1'b0; bus_din = 1'b1; #1;
        check("R7 dout follows tx_data 0", bus_dout, 1'b0);
        bus_clk_in = 1'b1;
        wait_half();
        check("R5 won holds", won, 1'b1);
    endtask

    task automatic t_preempted();
        do_reset();
        run_arb(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R5 preempted won", won, 1'b0);
        check("R6 preempted lost", lost, 1'b1);
    endtask

    task automatic t_arb_lose();
        do_reset();
        run_arb(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 arb lose won", won, 1'b0);
        check("R6 arb lose lost", lost, 1'b1);
    endtask

    task automatic t_prio_win();
        do_reset();
        run_arb(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 priority win", won, 1'b1);
        check("R5 priority win lost", lost, 1'b0);
    endtask

    task automatic t_prio_lose();
        do_reset();
        run_arb(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 priority lose won", won, 1'b0);
        check("R6 priority lose lost", lost, 1'b1);
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        for (int i = AW - 1; i >= 0; i--) begin
            bus_clk_in = 1'b0;
            bus_din = a[i];
            wait_half();
            bus_clk_in = 1'b1;
            wait_half();
        end
    endtask

    task automatic t_addr_match();
        do_reset();
        run_arb(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 non-participant lost", lost, 1'b0);
        send_addr(node_addr);
        check("R8 address match", addressed, 1'b1);
        check("R8 match not won", won, 1'b0);
    endtask

    task automatic t_addr_miss();
        do_reset();
        run_arb(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        send_addr(node_addr ^ 8'h01);
        check("R9 mismatch addressed", addressed, 1'b0);
        bus_din = 1'b0; #1;
        check("R9 ignore forwards 0", bus_dout, 1'b0);
        bus_din = 1'b1; #1;
        check("R9 ignore forwards 1", bus_dout, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_plain_win();
        t_preempted();
        t_arb_lose();
        t_prio_win();
        t_prio_lose();
        t_addr_match();
        t_addr_miss();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule